// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block turns an asynchronous, least-significant-bit-first NRZ serial line into parallel characters. It runs on the system clock and advances on a one-cycle 16x oversampling strobe. A mode input picks that strobe from one of two sources: an internal baud-rate generator or an externally supplied 16x receive clock, already reduced to a one-cycle pulse in the system clock domain. Character length runs from 5 to 8 data bits and is set by a two-bit field. An optional parity bit follows the data. It is checked in odd or even mode. In mark or space mode it is received and ignored.

A finished character goes to a holding register with a full flag, which the register block clears with a one-cycle read strobe. Overrun, framing and parity status stay asserted until the data has been read and a later character arrives without error. Reception stops whenever the receiver enable input is low or the data-set-ready input (active low) is high.

Top module: `uart_rx16`

## Requirements
- R1: Data bits arrive least significant bit first. `word_len` selects the count: 2'b00 = 8, 2'b01 = 7, 2'b10 = 6, 2'b11 = 5. Data bits above the selected length read as zero in `rx_data`.
- R2: When `clk_src_sel` is 1 the receiver counts `tick_int` strobes, and when it is 0 it counts `tick_ext` strobes.
- R3: A start bit begins on a high-to-low transition seen on a tick. It is confirmed by a sample taken 8 ticks later. If the line is high at that sample, the receiver returns to idle and delivers nothing.
- R4: With `par_en` = 1 and `par_mode` = 2'b00 (odd) or 2'b01 (even), the bit after the data is checked. `parity_err` is set when the number of ones across data and parity does not match the selected sense.
- R5: With `par_en` = 1 and `par_mode` = 2'b10 (mark) or 2'b11 (space), the parity bit is consumed but never raises `parity_err`.
- R6: `frame_err` is set when the first stop bit, sampled at its centre, is low.
- R7: `rx_full` rises when a character completes and clears in the cycle after a `data_rd` pulse.
- R8: When a character completes while `rx_full` is set and no read occurs in that cycle, `overrun` is set and `rx_data` keeps the earlier byte.
- R9: `overrun`, `frame_err` and `parity_err` change only when a character completes. After a read, the next character replaces them with its own status, so an error-free character clears them.
- R10: When `rx_enable` is 0 or `dsr_n` is 1, the receiver stays idle and no character is delivered.
- R11: After reset `rx_full`, `overrun`, `frame_err`, `parity_err` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_int | input | 1 | 16x strobe from the internal baud generator |
| tick_ext | input | 1 | 16x strobe derived from the external receive clock |
| clk_src_sel | input | 1 | 1 selects tick_int, 0 selects tick_ext |
| rxd | input | 1 | Serial data line, idle high |
| rx_enable | input | 1 | Receiver enable |
| dsr_n | input | 1 | Data set ready, active low; high disables the receiver |
| word_len | input | 2 | Character length code |
| par_en | input | 1 | Parity bit present |
| par_mode | input | 2 | 00 odd, 01 even, 10 mark, 11 space |
| data_rd | input | 1 | One-cycle read strobe for rx_data |
| rx_data | output | 8 | Last character accepted |
| rx_full | output | 1 | Holding register holds an unread character |
| overrun | output | 1 | A character arrived while the holding register was full |
| frame_err | output | 1 | First stop bit was low |
| parity_err | output | 1 | Parity check failed |

## Verification
The embedded properties watch the holding register on every cycle. They check that a read empties it and that unread data never changes. They check that the error flags move only at character completion, that overrun rises only with the register already full, and that the receiver is parked whenever it is disabled. Bit ordering, character lengths, parity sense, stop-bit sampling, start-glitch rejection and clock-source selection all depend on whole serial frames, so only the bench's frame sequences can show them, by comparing the delivered byte and flags against values worked out from the requirements.

// File: rtl/uart_rx16_pkg.sv
package uart_rx16_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   localparam logic [1:0] PAR_ODD   = 2'b00;
   localparam logic [1:0] PAR_EVEN  = 2'b01;
   localparam logic [1:0] PAR_MARK  = 2'b10;
   localparam logic [1:0] PAR_SPACE = 2'b11;

endpackage

// File: rtl/uart_rx16_front.sv
module uart_rx16_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rxd,
   input  logic tick_int,
   input  logic tick_ext,
   input  logic src_sel,
   output logic line_s,
   output logic tick
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_rx16_front: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= rxd;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b1;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   assign line_s = sync_q[SYNC_STAGES-1];
   assign tick   = src_sel ? tick_int : tick_ext;

endmodule

// File: rtl/uart_rx16_deser.sv
module uart_rx16_deser
   import uart_rx16_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_on,
   input  logic              tick,
   input  logic              line_s,
   input  logic [1:0]        word_len,
   input  logic              par_en,
   input  logic [1:0]        par_mode,
   output logic              done,
   output logic [DATA_W-1:0] dout,
   output logic              perr,
   output logic              ferr
);

   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("uart_rx16_deser: OVS must be a power of two of at least 4");
      end
      if (DATA_W < 5) begin : g_bad_w
         $error("uart_rx16_deser: DATA_W must be at least 5");
      end
   endgenerate

   rx_state_e          state;
   logic [CNT_W-1:0]   cnt;
   logic [IDX_W-1:0]   idx;
   logic [DATA_W-1:0]  shreg;
   logic               par_acc;
   logic               prev_line;
   logic [IDX_W:0]     nbits;
   logic               last_bit;
   logic               par_bad;

   assign nbits    = (IDX_W + 1)'(DATA_W) - (IDX_W + 1)'(word_len);
   assign last_bit = ({1'b0, idx} == nbits - 1'b1);
   assign par_bad  = !par_mode[1] && (par_acc ^ line_s ^ ~par_mode[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         idx       <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         prev_line <= 1'b1;
         done      <= 1'b0;
         dout      <= '0;
         perr      <= 1'b0;
         ferr      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!rx_on) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            prev_line <= 1'b1;
         end else if (tick) begin
            prev_line <= line_s;
            unique case (state)
               ST_IDLE: begin
                  if (prev_line && !line_s) begin
                     state <= ST_START;
                     cnt   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == HALF) begin
                     cnt <= '0;
                     if (!line_s) begin
                        state   <= ST_DATA;
                        idx     <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        perr    <= 1'b0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == LAST) begin
                     cnt        <= '0;
                     shreg[idx] <= line_s;
                     par_acc    <= par_acc ^ line_s;
                     if (last_bit) state <= par_en ? ST_PAR : ST_STOP;
                     else          idx   <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     perr  <= par_bad;
                     state <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     ferr  <= !line_s;
                     dout  <= shreg;
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R10: a disabled receiver is parked in idle
   a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_on |=> (state == ST_IDLE));

   // R3: the data phase is entered only from a confirmed start
   a_r3_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && $past(state) == ST_IDLE) |-> 1'b0);

endmodule

// File: rtl/uart_rx16_hold.sv
module uart_rx16_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] din,
   input  logic              perr_in,
   input  logic              ferr_in,
   input  logic              data_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              overrun,
   output logic              frame_err,
   output logic              parity_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data    <= '0;
         rx_full    <= 1'b0;
         overrun    <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
      end else if (done) begin
         if (rx_full && !data_rd) begin
            overrun <= 1'b1;
         end else begin
            rx_data    <= din;
            rx_full    <= 1'b1;
            overrun    <= 1'b0;
            frame_err  <= ferr_in;
            parity_err <= perr_in;
         end
      end else if (data_rd) begin
         rx_full <= 1'b0;
      end
   end

   // R7: a read with no arriving character empties the register
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !done) |=> !rx_full);

   // R8: unread data is never overwritten
   a_r8_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !data_rd) |=> $stable(rx_data));

   // R8: overrun only rises over a full register
   a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_full));

   // R9: error flags move only on a completed character
   a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable({overrun, frame_err, parity_err}));

endmodule

// File: rtl/uart_rx16.sv
module uart_rx16 #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_int,
   input  logic              tick_ext,
   input  logic              clk_src_sel,
   input  logic              rxd,
   input  logic              rx_enable,
   input  logic              dsr_n,
   input  logic [1:0]        word_len,
   input  logic              par_en,
   input  logic [1:0]        par_mode,
   input  logic              data_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              overrun,
   output logic              frame_err,
   output logic              parity_err
);

   logic              line_s;
   logic              tick;
   logic              rx_on;
   logic              done;
   logic [DATA_W-1:0] dout;
   logic              perr;
   logic              ferr;

   assign rx_on = rx_enable && !dsr_n;

   uart_rx16_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .rxd      (rxd),
      .tick_int (tick_int),
      .tick_ext (tick_ext),
      .src_sel  (clk_src_sel),
      .line_s   (line_s),
      .tick     (tick)
   );

   uart_rx16_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_on    (rx_on),
      .tick     (tick),
      .line_s   (line_s),
      .word_len (word_len),
      .par_en   (par_en),
      .par_mode (par_mode),
      .done     (done),
      .dout     (dout),
      .perr     (perr),
      .ferr     (ferr)
   );

   uart_rx16_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (done),
      .din        (dout),
      .perr_in    (perr),
      .ferr_in    (ferr),
      .data_rd    (data_rd),
      .rx_data    (rx_data),
      .rx_full    (rx_full),
      .overrun    (overrun),
      .frame_err  (frame_err),
      .parity_err (parity_err)
   );

   // R10: nothing is delivered while the receiver is off
   a_r10_no_delivery_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_on && $past(!rx_on)) |-> !done);

endmodule

// File: tb/sim_uart_rx16.sv
`timescale 1ns/1ps
module sim_uart_rx16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_int = 1'b0, tick_ext = 1'b0;
   logic       clk_src_sel = 1'b1;
   logic       rxd = 1'b1;
   logic       rx_enable = 1'b1;
   logic       dsr_n = 1'b0;
   logic [1:0] word_len = 2'b00;
   logic       par_en = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic       data_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, overrun, frame_err, parity_err;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;
   int div_i = 0, div_e = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      div_i <= (div_i == 3) ? 0 : div_i + 1;
      div_e <= (div_e == 7) ? 0 : div_e + 1;
      tick_int <= (div_i == 3);
      tick_ext <= (div_e == 7);
   end

   uart_rx16 u0 (
      .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .tick_ext(tick_ext),
      .clk_src_sel(clk_src_sel), .rxd(rxd), .rx_enable(rx_enable), .dsr_n(dsr_n),
      .word_len(word_len), .par_en(par_en), .par_mode(par_mode), .data_rd(data_rd),
      .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun),
      .frame_err(frame_err), .parity_err(parity_err)
   );

   typedef struct packed {
      logic [1:0] wl;
      logic       pe;
      logic [1:0] pm;
      logic [7:0] d;
      logic       badp;
      logic       bads;
      logic [7:0] xd;
      logic       xfe;
      logic       xpe;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{2'b00, 1'b0, 2'b00, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
      '{2'b11, 1'b0, 2'b00, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
      '{2'b01, 1'b1, 2'b00, 8'h53, 1'b0, 1'b0, 8'h53, 1'b0, 1'b0},
      '{2'b00, 1'b1, 2'b01, 8'h0F, 1'b1, 1'b0, 8'h0F, 1'b0, 1'b1},
      '{2'b10, 1'b1, 2'b10, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0},
      '{2'b00, 1'b0, 2'b00, 8'h81, 1'b0, 1'b1, 8'h81, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold_line(input logic v, input int clks);
      rxd = v;
      repeat (clks) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                       input logic [1:0] pm, input logic badp, input logic bads, input int bclk);
      int   nb;
      logic acc;
      logic pbit;
      nb  = 8 - int'(wl);
      acc = 1'b0;
      word_len = wl; par_en = pe; par_mode = pm;
      hold_line(1'b0, bclk);
      for (int i = 0; i < nb; i++) begin
         acc = acc ^ d[i];
         hold_line(d[i], bclk);
      end
      if (pe) begin
         case (pm)
            2'b00:   pbit = ~acc;
            2'b01:   pbit = acc;
            2'b10:   pbit = 1'b1;
            default: pbit = 1'b0;
         endcase
         hold_line(pbit ^ badp, bclk);
      end
      hold_line(!bads, bclk);
      hold_line(1'b1, 2 * bclk);
   endtask

   task automatic rd();
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset state
      chk("R11 full", rx_full, 0);
      chk("R11 flags", {overrun, frame_err, parity_err}, 0);
      chk("R11 data", rx_data, 0);
      rst_n = 1'b1;
      repeat (80) @(negedge clk);

      // table: R1 lengths, R4 parity, R5 mark, R6 framing, R7 full/read
      for (int v = 0; v < NV; v++) begin
         send(VEC[v].d, VEC[v].wl, VEC[v].pe, VEC[v].pm, VEC[v].badp, VEC[v].bads, 64);
         chk("R1 data", rx_data, VEC[v].xd);
         chk("R7 full set", rx_full, 1);
         chk("R6 frame", frame_err, VEC[v].xfe);
         chk("R4/R5 parity", parity_err, VEC[v].xpe);
         rd();
         chk("R7 read clears", rx_full, 0);
      end

      // R8/R9 overrun and sticky error
      send(8'hC3, 2'b00, 1'b1, 2'b01, 1'b1, 1'b0, 64);
      chk("R4 even bad", parity_err, 1);
      send(8'h11, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 64);
      chk("R8 overrun", overrun, 1);
      chk("R8 data kept", rx_data, 8'hC3);
      chk("R9 parity sticky", parity_err, 1);
      rd();
      send(8'h33, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 64);
      chk("R9 clean clears", {overrun, frame_err, parity_err}, 0);
      chk("R9 new data", rx_data, 8'h33);
      rd();

      // R10 enable and DSR gating
      rx_enable = 1'b0;
      send(8'h55, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 64);
      chk("R10 enable off", rx_full, 0);
      rx_enable = 1'b1; dsr_n = 1'b1;
      send(8'h55, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 64);
      chk("R10 dsr high", rx_full, 0);
      dsr_n = 1'b0;
      repeat (64) @(negedge clk);

      // R3 start glitch rejected
      hold_line(1'b0, 12);
      hold_line(1'b1, 128);
      chk("R3 glitch ignored", rx_full, 0);
      send(8'h6C, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 64);
      chk("R3 after glitch", rx_data, 8'h6C);
      rd();

      // R2 external tick source
      clk_src_sel = 1'b0;
      repeat (64) @(negedge clk);
      send(8'h9A, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 128);
      chk("R2 ext data", rx_data, 8'h9A);
      chk("R2 ext full", rx_full, 1);
      chk("R2 ext parity", parity_err, 0);
      rd();

      summary();
   end

endmodule